// File: doc/BRIEF.md
# Quarter-Rate Complex Frequency Shifter

This block moves the spectrum of a stream of complex baseband samples by exactly one quarter of the sample rate. It sits in a receive chain after an optional DC offset remover and ahead of a decimator that can be set to 1x, 2x, 4x, 8x, 16x or 32x. A shift of fs/4 multiplies successive samples by powers of j. Each product is therefore a swap of I and Q, a sign inversion, or both, and the block needs no multiplier.

A 2-bit run-time mode input selects one of three behaviours. The block can pass samples through unchanged, shift the spectrum up, or shift it down. A 2-bit rotation index advances once per accepted sample and selects the multiplier for that sample. Any change of mode restarts the sequence. Negating the most negative value saturates rather than wrapping. Results leave through a register stage, one cycle after the sample is accepted.

Top module: `quarter_rate_shifter`

## Requirements
- R1: While reset is low, and in the first cycle after it, out_valid is 0 and out_i and out_q are 0.
- R2: out_valid in a cycle equals in_valid in the previous cycle, giving one cycle of latency.
- R3: With mode 2'b00 or mode 2'b11 (both bypass), an accepted sample appears unchanged on out_i/out_q one cycle later.
- R4: With mode 2'b01 (shift up), successive accepted samples are multiplied by 1, +j, -1, -j, and the sequence then repeats. The products are: +j maps (I,Q) to (-Q,I), -1 maps (I,Q) to (-I,-Q), and -j maps (I,Q) to (Q,-I).
- R5: With mode 2'b10 (shift down), successive accepted samples are multiplied by 1, -j, -1, +j, and the sequence then repeats. The products are the same as in R4.
- R6: A cycle with in_valid low does not advance the rotation index, and out_i and out_q keep their previous values.
- R7: Negating the 8-bit value -128 (8'h80) gives +127 (8'h7F). Any other value negates exactly.
- R8: The first accepted sample after the mode input differs from the mode of the previous accepted sample uses multiplier 1. The sequence then continues from there. The mode held at reset counts as 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 00 bypass, 01 shift up, 10 shift down, 11 bypass |
| in_valid | input | 1 | Input sample is present this cycle |
| in_i | input | 8 | Input in-phase component, two's complement |
| in_q | input | 8 | Input quadrature component, two's complement |
| out_valid | output | 1 | Output sample is present this cycle |
| out_i | output | 8 | Output in-phase component, two's complement |
| out_q | output | 8 | Output quadrature component, two's complement |

## Verification
The rotated or bypassed result of a sample accepted at a rising edge is due on the outputs after the next rising edge, together with out_valid. Idle cycles must leave the data unchanged at that same point. The bench drives each stimulus on the falling edge and samples 1 ns after the following rising edge, so every comparison is made exactly one register stage after its input. The bench keeps its own rotation index and last-mode record, updated only on accepted samples, so that restarts after a mode change and gaps in valid are predicted at the cycle they take effect.

// File: rtl/qrs_pkg.sv
// Package: shared mode encoding and rotation codes for the quarter-rate shifter.
// Assumes two's complement sample components.
package qrs_pkg;

    // Run-time shift selection; the last code is a second bypass encoding.
    typedef enum logic [1:0] {
        MODE_PASS     = 2'b00,
        MODE_UP       = 2'b01,
        MODE_DOWN     = 2'b10,
        MODE_PASS_ALT = 2'b11
    } shift_mode_e;

    // Rotation applied to one sample, in quarter turns counter-clockwise.
    typedef enum logic [1:0] {
        ROT_0   = 2'd0,   // multiply by 1
        ROT_90  = 2'd1,   // multiply by +j
        ROT_180 = 2'd2,   // multiply by -1
        ROT_270 = 2'd3    // multiply by -j
    } rot_code_e;

endpackage

// File: rtl/qrs_sat_neg.sv
// Module: saturating two's complement negation of one component.
// Purely combinational. The most negative input maps to the most positive
// value, because its true negation does not fit in W bits.
module qrs_sat_neg #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    // Negate, clamping the single value that would overflow.
    always_comb begin
        if (a == MOST_NEG) y = MOST_POS;
        else               y = (~a) + ONE;
    end

    // A negation can never produce the most negative code.
    always_comb begin
        AST_NEG_NO_WRAP: assert (y != MOST_NEG); // R7
    end
endmodule

// File: rtl/qrs_phase_ctrl.sv
// Module: rotation sequencer.
// Tracks the quarter-turn index of the current sample, which advances only on
// accepted samples and restarts at zero when the mode differs from the mode of
// the previous accepted sample. It turns the index into a rotation code for
// the selected direction. It assumes the mode may change in any cycle.
module qrs_phase_ctrl
    import qrs_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [1:0]       mode,
    output logic [IDX_W-1:0] rot_code
);
    localparam logic [IDX_W-1:0] IDX_ONE = {{(IDX_W-1){1'b0}}, 1'b1};

    logic [IDX_W-1:0] idx_q;
    logic [1:0]       last_mode_q;
    logic [IDX_W-1:0] cur_idx;
    logic             mode_changed;

    // Detect a mode change against the last accepted sample and pick the index.
    always_comb begin
        mode_changed = (mode != last_mode_q);
        cur_idx      = mode_changed ? '0 : idx_q;
    end

    // Map the index to a rotation: forward when shifting up, reversed when down.
    always_comb begin
        unique case (shift_mode_e'(mode))
            MODE_UP:   rot_code = cur_idx;
            MODE_DOWN: rot_code = '0 - cur_idx;
            default:   rot_code = '0;
        endcase
    end

    // Advance the index and remember the mode on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q       <= '0;
            last_mode_q <= MODE_PASS;
        end else if (accept) begin
            idx_q       <= cur_idx + IDX_ONE;
            last_mode_q <= mode;
        end
    end

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !accept |=> $stable(idx_q)); // R6
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n) (accept && !mode_changed) |=> idx_q == $past(idx_q) + IDX_ONE); // R4
    AST_IDX_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (accept && mode_changed) |=> idx_q == IDX_ONE); // R8
endmodule

// File: rtl/qrs_rotator.sv
// Module: quarter-turn rotator for one complex sample.
// Combinational swap/negate network. Needs no multiplier. Negation saturates.
module qrs_rotator
    import qrs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] re_in,
    input  logic [W-1:0] im_in,
    input  logic [1:0]   rot,
    output logic [W-1:0] re_out,
    output logic [W-1:0] im_out
);
    logic [W-1:0] re_neg;
    logic [W-1:0] im_neg;

    qrs_sat_neg #(.W(W)) u_neg_re (.a(re_in), .y(re_neg));
    qrs_sat_neg #(.W(W)) u_neg_im (.a(im_in), .y(im_neg));

    // Select the swapped and/or negated components for the requested turn.
    always_comb begin
        unique case (rot_code_e'(rot))
            ROT_90:  begin re_out = im_neg; im_out = re_in;  end
            ROT_180: begin re_out = re_neg; im_out = im_neg; end
            ROT_270: begin re_out = im_in;  im_out = re_neg; end
            default: begin re_out = re_in;  im_out = im_in;  end
        endcase
    end
endmodule

// File: rtl/quarter_rate_shifter.sv
// Module: fs/4 complex frequency shifter, top level.
// Rotates each accepted I/Q sample by the quarter turn that the sequencer
// chooses, then registers the result. Latency is one cycle. The output data
// holds its value during cycles with no input. Assumes in_valid is free to
// toggle every cycle; there is no back-pressure.
module quarter_rate_shifter
    import qrs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_i,
    input  logic [DATA_W-1:0] in_q,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_i,
    output logic [DATA_W-1:0] out_q
);
    localparam int IDX_W = 2;

    logic [IDX_W-1:0]  rot_code;
    logic [DATA_W-1:0] rot_i;
    logic [DATA_W-1:0] rot_q;
    logic              is_bypass;

    qrs_phase_ctrl #(.IDX_W(IDX_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (in_valid),
        .mode     (mode),
        .rot_code (rot_code)
    );

    qrs_rotator #(.W(DATA_W)) u_rot (
        .re_in  (in_i),
        .im_in  (in_q),
        .rot    (rot_code),
        .re_out (rot_i),
        .im_out (rot_q)
    );

    // Flag both bypass encodings for the checks below.
    always_comb begin
        is_bypass = (mode == MODE_PASS) || (mode == MODE_PASS_ALT);
    end

    // Output register: valid follows input, data loads only on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_i <= rot_i;
                out_q <= rot_q;
            end
        end
    end

    AST_VALID_ON: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
    AST_VALID_OFF: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> ($stable(out_i) && $stable(out_q))); // R6
    AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && is_bypass) |=> (out_i == $past(in_i) && out_q == $past(in_q))); // R3
endmodule

// File: tb/tb_quarter_rate_shifter.sv
// Bench: directed corner cases followed by seeded random stimulus. The
// expected outputs come from a behavioural model kept in the bench.
module tb_quarter_rate_shifter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       in_valid = 1'b0;
    logic [7:0] in_i = '0;
    logic [7:0] in_q = '0;
    logic       out_valid;
    logic [7:0] out_i;
    logic [7:0] out_q;

    int checks = 0;
    int errors = 0;

    // Behavioural model state
    int         m_idx = 0;
    logic [1:0] m_last = 2'b00;
    logic [7:0] e_i = '0;
    logic [7:0] e_q = '0;

    always #2 clk = ~clk;   // 250 MHz

    quarter_rate_shifter dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    function automatic logic [7:0] neg8(input logic [7:0] x);
        return (x == 8'h80) ? 8'h7F : (8'd0 - x);
    endfunction

    // Multiplier for sequence position k: 0 -> 1, 1 -> +j, 2 -> -1, 3 -> -j
    function automatic void mulj(input int k, input logic [7:0] i, input logic [7:0] q,
                                 output logic [7:0] ri, output logic [7:0] rq);
        case (k)
            1: begin ri = neg8(q); rq = i;       end
            2: begin ri = neg8(i); rq = neg8(q); end
            3: begin ri = q;       rq = neg8(i); end
            default: begin ri = i; rq = q;       end
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive on the falling edge, check one register stage later.
    task automatic step(input logic v, input logic [1:0] m, input logic [7:0] i,
                        input logic [7:0] q, input string tag);
        int k;
        int pos;
        @(negedge clk);
        in_valid = v; mode = m; in_i = i; in_q = q;
        if (v) begin
            pos = (m != m_last) ? 0 : m_idx;
            if (m == 2'b01)      k = pos;
            else if (m == 2'b10) k = (4 - pos) % 4;   // 1, -j, -1, +j
            else                 k = 0;
            mulj(k, i, q, e_i, e_q);
            m_idx  = (pos + 1) % 4;
            m_last = m;
        end
        @(posedge clk); #1;
        check({tag, " R2 valid"}, {31'd0, out_valid}, {31'd0, v});
        check({tag, " data I"}, {24'd0, out_i}, {24'd0, e_i});
        check({tag, " data Q"}, {24'd0, out_q}, {24'd0, e_q});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        in_valid = 1'b1; in_i = 8'h55; in_q = 8'h22;   // activity under reset is ignored
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
        check("R1 I in reset", {24'd0, out_i}, 32'd0);
        check("R1 Q in reset", {24'd0, out_q}, 32'd0);
        @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;
        @(posedge clk); #1;
        check("R1 valid after reset", {31'd0, out_valid}, 32'd0);
        check("R1 I after reset", {24'd0, out_i}, 32'd0);

        // R3: both bypass encodings
        step(1, 2'b00, 8'h12, 8'hF0, "R3 bypass 00");
        step(1, 2'b11, 8'h80, 8'h7F, "R3 bypass 11");
        // R4: shift up over two periods
        for (int n = 0; n < 8; n++) step(1, 2'b01, 8'(10 + n), 8'(8'hE0 + n), "R4 up");
        // R6: idle gap holds index and data
        step(0, 2'b01, 8'hAA, 8'hBB, "R6 idle");
        step(0, 2'b01, 8'h01, 8'h02, "R6 idle");
        step(1, 2'b01, 8'h30, 8'h40, "R6 resume");
        // R8: mode change mid sequence restarts at multiplier 1
        step(1, 2'b10, 8'h05, 8'h06, "R8 restart");
        // R5: shift down
        for (int n = 0; n < 8; n++) step(1, 2'b10, 8'(8'h20 + n), 8'(8'h90 + n), "R5 down");
        // R7: most negative value through every negating position
        for (int n = 0; n < 4; n++) step(1, 2'b01, 8'h80, 8'h80, "R7 sat up");
        for (int n = 0; n < 4; n++) step(1, 2'b10, 8'h80, 8'h7F, "R7 sat down");
        // R8: a mode change during idle takes effect on the next accepted sample
        step(1, 2'b01, 8'h11, 8'h22, "R8 pre");
        step(0, 2'b00, 8'h00, 8'h00, "R8 idle");
        step(1, 2'b01, 8'h33, 8'h44, "R8 same");

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] rm;
            logic [7:0] ri, rq;
            rm = ($urandom % 16 == 0) ? 2'($urandom) : mode;
            ri = ($urandom % 8 == 0) ? 8'h80 : 8'($urandom);
            rq = ($urandom % 8 == 0) ? 8'h80 : 8'($urandom);
            step(($urandom % 4) != 0, rm, ri, rq, "R4 R5 R6 R8 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule